// File: doc/BRIEF.md
# Bus Cycle Termination Classifier

This block watches the handshake lines that end an asynchronous bus cycle and decides how each cycle ended. It sees a cycle strobe, a two-bit data-size acknowledge, an autovector acknowledge, a bus-error request and a halt request. All of these arrive asynchronously and are synchronized before any decision is made. Inside a cycle the block records when the halt and bus-error requests first appeared: before the acknowledge, in the same sample as the acknowledge, or after it. It also records the port width that the acknowledge reported.

When the strobe drops, the block issues a one-clock done pulse. It presents a registered outcome: normal completion, halted completion, bus-error termination, or no termination at all. It also presents the port width, the order codes for halt and bus error, and a late-error flag. These outputs hold their values until the next strobe assertion clears them. Retry handling, exception processing and the bus master sequencing belong to the surrounding logic.

Top module: `bus_term_classifier`

## Requirements
- R1: Every input passes through a two-stage synchronizer. The outcome registers and `term_done` update on the third rising clock edge after the raw `cyc_req` falls. `term_done` is high for exactly one clock per cycle.
- R2: An acknowledge (`ack_lines` nonzero or `avec_ack` high) with no halt or bus error before or with it gives `term_kind` = 2'b01 (normal).
- R3: Halt seen before or in the same sample as the acknowledge, with no bus error before or with it, gives `term_kind` = 2'b10 (halt).
- R4: Bus error seen before, with, or instead of the acknowledge gives `term_kind` = 2'b11 (bus error). Bus error takes priority over halt.
- R5: `port_width` is 2'b01 for acknowledge 2'b01 (8-bit) and 2'b10 for acknowledge 2'b10 or 2'b11 (16-bit). It is 2'b11 for an autovector acknowledge and 2'b00 when no acknowledge was taken. The first acknowledge sample in a cycle is the one captured.
- R6: A bus error first seen after the acknowledge sets `late_berr` = 1 and `berr_order` = 2'b11, and does not change `term_kind`.
- R7: `halt_order` and `berr_order` use these codes: 2'b00 absent, 2'b01 before the acknowledge (or with no acknowledge), 2'b10 same sample, 2'b11 after. A halt that first appears after the acknowledge gives `halt_order` = 2'b11 and leaves `term_kind` unchanged.
- R8: A cycle whose strobe drops with neither an acknowledge nor a bus error still pulses `term_done`, with `term_kind` = 2'b00 and `port_width` = 2'b00.
- R9: The outputs hold until the next strobe assertion. On the third rising edge after the raw `cyc_req` rises, all outcome outputs return to zero.
- R10: Halt, bus error and acknowledge activity while the strobe is low has no effect on the next cycle's result.
- R11: Once a bus error has ended a cycle with no acknowledge, a later acknowledge in that cycle is ignored and `port_width` stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_req | input | 1 | Bus cycle strobe, asynchronous, high during a cycle |
| ack_lines | input | 2 | Data-size acknowledge, asynchronous |
| avec_ack | input | 1 | Autovector acknowledge, asynchronous |
| berr_req | input | 1 | Bus-error request, asynchronous |
| halt_req | input | 1 | Halt request, asynchronous |
| term_done | output | 1 | One-clock pulse when a cycle's outcome is loaded |
| term_kind | output | 2 | Outcome: 00 none, 01 normal, 10 halt, 11 bus error |
| port_width | output | 2 | 00 none, 01 8-bit, 10 16-bit, 11 autovector |
| halt_order | output | 2 | Halt arrival relative to the acknowledge |
| berr_order | output | 2 | Bus-error arrival relative to the acknowledge |
| late_berr | output | 1 | Bus error arrived after the acknowledge |

## Verification
A corrupted order tracker or a stuck acknowledge flag shows up at the ports only at the done pulse. There, `term_kind`, `port_width` or an order code disagrees with the sequence that was driven, three clocks after the strobe falls. A result register that fails to hold or fails to clear shows while the strobe is low as an output that changes without a done pulse, or three clocks after the strobe rises as an output that stays nonzero. The arrival-order cases (early, same-sample and late halt or bus error) are each driven on their own, so that a swapped priority or a wrong order code yields a specific wrong code.

// File: rtl/bterm_pkg.sv
// Package: shared encodings for the bus cycle termination classifier.
// Assumes: every code fits in two bits and the value zero means "nothing".
package bterm_pkg;

    localparam int SYNC_STAGES = 2;
    localparam int ACK_W       = 2;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_NORMAL = 2'b01,
        KIND_HALT   = 2'b10,
        KIND_BERR   = 2'b11
    } term_kind_e;

    typedef enum logic [1:0] {
        ORD_ABSENT = 2'b00,
        ORD_EARLY  = 2'b01,
        ORD_SAME   = 2'b10,
        ORD_LATE   = 2'b11
    } order_e;

    typedef enum logic [1:0] {
        PW_NONE = 2'b00,
        PW_BYTE = 2'b01,
        PW_WORD = 2'b10,
        PW_AUTO = 2'b11
    } width_e;

    // Map a raw acknowledge sample to a port width code.
    function automatic width_e ack_to_width(input logic [ACK_W-1:0] ack, input logic avec);
        if (ack[1])
            return PW_WORD;
        else if (ack[0])
            return PW_BYTE;
        else if (avec)
            return PW_AUTO;
        return PW_NONE;
    endfunction

endpackage

// File: rtl/bterm_sync.sv
// Module: multi-bit flop-chain synchronizer for asynchronous handshake lines.
// Assumes: each bit is an independent level, so skew between bits is acceptable.
module bterm_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw lines into the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= async_in;
                end
            end else begin : g_next
                // Shift the previous stage forward.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[LAST];
endmodule

// File: rtl/bterm_order.sv
// Module: records when an event first appears relative to the acknowledge.
// Assumes: ack_now is high only for the single sample in which the acknowledge
// is taken, and ack_prior is high in every later sample of the same cycle.
module bterm_order
    import bterm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   evt,
    input  logic   ack_now,
    input  logic   ack_prior,
    output order_e order
);
    // Latch the first arrival of the event and keep it until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            order <= ORD_ABSENT;
        end else if (clear) begin
            order <= ORD_ABSENT;
        end else if (evt && order == ORD_ABSENT) begin
            if (ack_prior)
                order <= ORD_LATE;
            else if (ack_now)
                order <= ORD_SAME;
            else
                order <= ORD_EARLY;
        end
    end
endmodule

// File: rtl/bterm_result.sv
// Module: classifies a finished cycle and holds the registered outcome.
// Assumes: start and finish are never high in the same clock.
module bterm_result
    import bterm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       finish,
    input  logic       ack_seen,
    input  width_e     width_in,
    input  order_e     halt_in,
    input  order_e     berr_in,
    output logic       done,
    output term_kind_e kind,
    output width_e     width,
    output order_e     halt_ord,
    output order_e     berr_ord,
    output logic       late
);
    term_kind_e kind_next;
    logic       berr_term;
    logic       halt_term;

    // Decide the outcome: bus error first, then halt, then normal.
    always_comb begin
        berr_term = (berr_in == ORD_EARLY) || (berr_in == ORD_SAME);
        halt_term = (halt_in == ORD_EARLY) || (halt_in == ORD_SAME);
        if (berr_term)
            kind_next = KIND_BERR;
        else if (ack_seen)
            kind_next = halt_term ? KIND_HALT : KIND_NORMAL;
        else
            kind_next = KIND_NONE;
    end

    // Pulse done at cycle end; load on finish, clear on the next start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            kind     <= KIND_NONE;
            width    <= PW_NONE;
            halt_ord <= ORD_ABSENT;
            berr_ord <= ORD_ABSENT;
            late     <= 1'b0;
        end else begin
            done <= finish;
            if (start) begin
                kind     <= KIND_NONE;
                width    <= PW_NONE;
                halt_ord <= ORD_ABSENT;
                berr_ord <= ORD_ABSENT;
                late     <= 1'b0;
            end else if (finish) begin
                kind     <= kind_next;
                width    <= width_in;
                halt_ord <= halt_in;
                berr_ord <= berr_in;
                late     <= (berr_in == ORD_LATE);
            end
        end
    end
endmodule

// File: rtl/bus_term_classifier.sv
// Module: top of the bus cycle termination classifier.
// Synchronizes the handshake lines, tracks acknowledge, halt and bus-error
// arrival order during a cycle, and emits a registered outcome at cycle end.
// Assumes: the strobe stays low for at least one synchronized sample between cycles.
module bus_term_classifier
    import bterm_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_req,
    input  logic [1:0] ack_lines,
    input  logic       avec_ack,
    input  logic       berr_req,
    input  logic       halt_req,
    output logic       term_done,
    output logic [1:0] term_kind,
    output logic [1:0] port_width,
    output logic [1:0] halt_order,
    output logic [1:0] berr_order,
    output logic       late_berr
);
    localparam int NUM_EVT = 2;
    localparam int IN_W    = ACK_W + 4;

    logic [IN_W-1:0]  raw_bus;
    logic [IN_W-1:0]  sync_bus;
    logic             cyc_s;
    logic [ACK_W-1:0] ack_s;
    logic             avec_s;
    logic             berr_s;
    logic             halt_s;
    logic             cyc_q;
    logic             cyc_start;
    logic             cyc_end;
    logic             ack_any;
    logic             ack_take;
    logic             ack_seen;
    width_e           width_q;
    logic [NUM_EVT-1:0] evt_vec;
    order_e           ord_vec [NUM_EVT];
    order_e           berr_ord_int;
    order_e           halt_ord_int;
    term_kind_e       kind_o;
    width_e           width_o;
    order_e           halt_o;
    order_e           berr_o;

    assign raw_bus = {cyc_req, ack_lines, avec_ack, berr_req, halt_req};

    bterm_sync #(.WIDTH(IN_W), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_bus),
        .sync_out (sync_bus)
    );

    assign {cyc_s, ack_s, avec_s, berr_s, halt_s} = sync_bus;

    // Remember the previous strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cyc_q <= 1'b0;
        else        cyc_q <= cyc_s;
    end

    assign cyc_start = cyc_s & ~cyc_q;
    assign cyc_end   = ~cyc_s & cyc_q;
    assign ack_any   = (|ack_s) | avec_s;
    // An acknowledge counts only once, and not after a bus error already ended the cycle.
    assign ack_take  = cyc_s & ack_any & ~ack_seen & (berr_ord_int == ORD_ABSENT);

    // Track the first acknowledge of the cycle and the width it reports.
    always_ff @(posedge clk) begin
        if (!rst_n || cyc_end) begin
            ack_seen <= 1'b0;
            width_q  <= PW_NONE;
        end else if (ack_take) begin
            ack_seen <= 1'b1;
            width_q  <= ack_to_width(ack_s, avec_s);
        end
    end

    assign evt_vec = {cyc_s & berr_s, cyc_s & halt_s};

    generate
        for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
            bterm_order u_order (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (cyc_end),
                .evt       (evt_vec[e]),
                .ack_now   (ack_take),
                .ack_prior (ack_seen),
                .order     (ord_vec[e])
            );
        end
    endgenerate

    assign halt_ord_int = ord_vec[0];
    assign berr_ord_int = ord_vec[1];

    bterm_result u_result (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cyc_start),
        .finish   (cyc_end),
        .ack_seen (ack_seen),
        .width_in (width_q),
        .halt_in  (halt_ord_int),
        .berr_in  (berr_ord_int),
        .done     (term_done),
        .kind     (kind_o),
        .width    (width_o),
        .halt_ord (halt_o),
        .berr_ord (berr_o),
        .late     (late_berr)
    );

    assign term_kind  = kind_o;
    assign port_width = width_o;
    assign halt_order = halt_o;
    assign berr_order = berr_o;
endmodule

// File: rtl/bus_term_classifier_chk.sv
// Module: property checker for the termination classifier, bound to the top.
// Assumes: cyc_start and cyc_end are the top's synchronized strobe edges.
module bus_term_classifier_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_start,
    input logic       cyc_end,
    input logic       term_done,
    input logic [1:0] term_kind,
    input logic [1:0] port_width,
    input logic [1:0] halt_order,
    input logic [1:0] berr_order,
    input logic       late_berr
);
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        term_done |=> !term_done);

    assert_done_after_end_R1: assert property (@(posedge clk) disable iff (!rst_n)
        term_done |-> $past(cyc_end));

    assert_normal_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (term_kind == 2'b01) |-> (halt_order != 2'b01 && halt_order != 2'b10
                                  && berr_order != 2'b01 && berr_order != 2'b10
                                  && port_width != 2'b00));

    assert_halt_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (term_kind == 2'b10) |-> ((halt_order == 2'b01 || halt_order == 2'b10)
                                  && port_width != 2'b00));

    assert_berr_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (term_kind == 2'b11) |-> (berr_order == 2'b01 || berr_order == 2'b10));

    assert_late_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        late_berr |-> (berr_order == 2'b11 && term_kind != 2'b11));

    assert_none_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (term_kind == 2'b00) |-> (port_width == 2'b00 && !late_berr));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_start && !cyc_end) |=> ($stable(term_kind) && $stable(port_width)
                                      && $stable(halt_order) && $stable(berr_order)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> (term_kind == 2'b00 && port_width == 2'b00 && !term_done));
endmodule

bind bus_term_classifier bus_term_classifier_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .cyc_end    (cyc_end),
    .term_done  (term_done),
    .term_kind  (term_kind),
    .port_width (port_width),
    .halt_order (halt_order),
    .berr_order (berr_order),
    .late_berr  (late_berr)
);

// File: tb/bus_term_classifier_bench.sv
// Bench: table-driven cycles followed by directed latency, hold and idle tests.
module bus_term_classifier_bench;

    typedef struct packed {
        logic       a_halt;
        logic       a_berr;
        logic [1:0] b_ack;
        logic       b_avec;
        logic       b_halt;
        logic       b_berr;
        logic       c_halt;
        logic       c_berr;
        logic [1:0] k;
        logic [1:0] w;
        logic [1:0] ht;
        logic [1:0] bt;
        logic       late;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b10,2'b00,2'b00,1'b0}, // R2 normal 16
        '{1'b0,1'b0,2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,2'b00,2'b00,1'b0}, // R5 8-bit
        '{1'b0,1'b0,2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b10,2'b00,2'b00,1'b0}, // R5 ack 11
        '{1'b0,1'b0,2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,2'b01,2'b11,2'b00,2'b00,1'b0}, // R5 autovector
        '{1'b1,1'b0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b10,2'b10,2'b01,2'b00,1'b0}, // R3 halt early
        '{1'b0,1'b0,2'b01,1'b0,1'b1,1'b0,1'b0,1'b0,2'b10,2'b01,2'b10,2'b00,1'b0}, // R3 halt same
        '{1'b0,1'b0,2'b10,1'b0,1'b0,1'b1,1'b0,1'b0,2'b11,2'b10,2'b00,2'b10,1'b0}, // R4 berr same
        '{1'b0,1'b1,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,2'b01,1'b0}, // R11 berr early
        '{1'b0,1'b1,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b00,2'b01,1'b0}, // R4 berr only
        '{1'b0,1'b0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b10,2'b00,2'b11,1'b1}, // R6 late berr
        '{1'b0,1'b0,2'b01,1'b0,1'b0,1'b0,1'b1,1'b0,2'b01,2'b01,2'b11,2'b00,1'b0}, // R7 late halt
        '{1'b1,1'b1,2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,2'b11,2'b00,2'b01,2'b01,1'b0}, // R4 berr over halt
        '{1'b0,1'b0,2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,2'b00,2'b00,1'b0}, // R8 none
        '{1'b1,1'b0,2'b10,1'b0,1'b0,1'b0,1'b0,1'b1,2'b10,2'b10,2'b01,2'b11,1'b1}  // R6 halt+late berr
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_req = 1'b0;
    logic [1:0] ack_lines = 2'b00;
    logic       avec_ack = 1'b0;
    logic       berr_req = 1'b0;
    logic       halt_req = 1'b0;
    logic       term_done;
    logic [1:0] term_kind;
    logic [1:0] port_width;
    logic [1:0] halt_order;
    logic [1:0] berr_order;
    logic       late_berr;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bus_term_classifier u_bus_term_classifier (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_req    (cyc_req),
        .ack_lines  (ack_lines),
        .avec_ack   (avec_ack),
        .berr_req   (berr_req),
        .halt_req   (halt_req),
        .term_done  (term_done),
        .term_kind  (term_kind),
        .port_width (port_width),
        .halt_order (halt_order),
        .berr_order (berr_order),
        .late_berr  (late_berr)
    );

    // Count done pulses away from the active edge.
    always @(negedge clk) if (term_done) done_cnt++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive(input logic h, input logic b, input logic [1:0] a, input logic av);
        halt_req  = h;
        berr_req  = b;
        ack_lines = a;
        avec_ack  = av;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Run one cycle in three phases (before, at and after the acknowledge) and check.
    task automatic run_vec(input vec_t v, input string tag);
        wait_neg(1);
        cyc_req = 1'b1;
        wait_neg(4);
        drive(v.a_halt, v.a_berr, 2'b00, 1'b0);
        wait_neg(4);
        drive(v.b_halt, v.b_berr, v.b_ack, v.b_avec);
        wait_neg(4);
        drive(v.c_halt, v.c_berr, 2'b00, 1'b0);
        wait_neg(4);
        done_cnt = 0;
        drive(1'b0, 1'b0, 2'b00, 1'b0);
        cyc_req = 1'b0;
        wait_neg(6);
        check({tag, " kind"},  term_kind,  v.k);
        check({tag, " width"}, port_width, v.w);
        check({tag, " halt_order"}, halt_order, v.ht);
        check({tag, " berr_order"}, berr_order, v.bt);
        check({tag, " late_berr"},  late_berr,  v.late);
        check({tag, " R1 done count"}, done_cnt, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_neg(4);
        // Reset state.
        check("R9 reset kind", term_kind, 0);
        check("R1 reset done", term_done, 0);
        rst_n = 1'b1;
        wait_neg(2);
        check("R9 reset width", port_width, 0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i], $sformatf("vec%0d", i));
        end

        // R1: latency from raw strobe fall to the done pulse.
        wait_neg(1);
        cyc_req = 1'b1;
        wait_neg(4);
        ack_lines = 2'b10;
        wait_neg(4);
        cyc_req = 1'b0;
        ack_lines = 2'b00;
        wait_neg(2);
        check("R1 done not yet", term_done, 0);
        check("R1 kind not yet", term_kind, 0);
        wait_neg(1);
        check("R1 done at third edge", term_done, 1);
        check("R1 kind at third edge", term_kind, 1);
        wait_neg(1);
        check("R1 done one clock", term_done, 0);

        // R9: hold while idle, clear three edges after strobe rise.
        wait_neg(20);
        check("R9 held kind", term_kind, 1);
        check("R9 held width", port_width, 2);
        cyc_req = 1'b1;
        wait_neg(2);
        check("R9 still held", term_kind, 1);
        wait_neg(1);
        check("R9 cleared kind", term_kind, 0);
        check("R9 cleared width", port_width, 0);
        wait_neg(3);
        cyc_req = 1'b0;
        wait_neg(6);

        // R10: activity with the strobe low must not leak into the next cycle.
        drive(1'b1, 1'b1, 2'b01, 1'b1);
        wait_neg(8);
        drive(1'b0, 1'b0, 2'b00, 1'b0);
        wait_neg(4);
        run_vec(VEC[0], "R10 idle noise");

        finish_run();
    end
endmodule